// File: doc/BRIEF.md
# Lockable Upper DRAM Window Registers

This block holds two memory-map settings used by a host bridge and decides, for each host address, whether it falls in the DRAM window that lies above the 4 GB boundary. The first setting is a 16-bit upper limit expressed in 1 MB units. It is the first address past the usable DRAM above 4 GB. The second is a 32-bit graphics base word. Only its bits 31:20 are stored, and they give the start of the DRAM carved out for graphics.

Configuration software programs both settings through a plain register port: a write strobe, a byte offset, four byte enables and 32-bit data, with a combinational read-back. Three lock inputs protect the settings. A trusted-mode level freezes the upper limit. A management level freezes the graphics base. A one-cycle lock command freezes the graphics base until the next reset. The address decode is combinational, so a new limit value governs every address presented after the write edge. All pins are plain control and status signals: nothing here streams, so no valid/ready handshake or back-pressure applies.

Top module: `dram_window_regs`

## Requirements
- R1: After reset, both settings read back as zero and `dram_hit` is 0 for every address.
- R2: The upper limit is read and written at word offset 0 (cfg_off[3:2]=0) in data bits 15:0. It takes byte enables 0 and 1. Bits 31:16 of that word read as zero, and writes to them are ignored.
- R3: The graphics base is read and written at word offset 1 (cfg_off[3:2]=1). Only bits 31:20 are writable, under byte enables 2 and 3. Bits 19:0 always read as zero.
- R4: `dram_hit` is 1 exactly when host_addr is at or above 2^32 and host_addr[35:20] is strictly less than the upper limit. Address bits 19:0 have no influence.
- R5: When the upper limit is 16'h1000 (4 GB) or lower, `dram_hit` never asserts.
- R6: While `trust_lock` is 1, writes to the upper limit are ignored. Once the input drops, writes take effect again.
- R7: While `mgmt_lock` is 1, writes to the graphics base are ignored. Once the input drops, writes take effect again.
- R8: A `lock_cmd` pulse makes the graphics base read-only from that same cycle until reset, and a write in the pulse cycle is also ignored. The upper limit is not affected by it.
- R9: A write to word offsets 2 and 3 changes neither setting, and reads at those offsets return zero.
- R10: A new upper limit governs `dram_hit` from the first address that follows its write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_off | input | 4 | Byte offset; bits 3:2 select the word |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_off (combinational) |
| trust_lock | input | 1 | Level lock for the upper limit |
| mgmt_lock | input | 1 | Level lock for the graphics base |
| lock_cmd | input | 1 | Pulse that locks the graphics base until reset |
| host_addr | input | 36 | Host address to decode |
| dram_hit | output | 1 | Address lies in the upper DRAM window |

## Verification
The decode is swept over all 65536 values of the 1 MB region index. This is done under limits of zero, just below 4 GB, exactly 4 GB, one step above 4 GB, a mid value and the maximum, so that the lower bound and the half-open upper bound are tested separately. The low 20 address bits alternate between all-zeros and all-ones to show that they are ignored. Writes are tried with single and combined byte enables, under each lock source on its own, in the same cycle as the lock command, and to unmapped offsets. Each case is followed by a read-back, which tells the level locks from the sticky one.

// File: rtl/dram_win_pkg.sv
package dram_win_pkg;
  localparam int ADDR_W    = 36;
  localparam int GRAN_SH   = 20;
  localparam int LIM_W     = ADDR_W - GRAN_SH;
  localparam int DATA_W    = 32;
  localparam int BE_W      = DATA_W / 8;
  localparam int LOW_GB_SH = 32;
  localparam logic [LIM_W-1:0] FOUR_GB_REGION = LIM_W'(1) << (LOW_GB_SH - GRAN_SH);
  localparam logic [1:0] WORD_LIMIT = 2'd0;
  localparam logic [1:0] WORD_GFX   = 2'd1;
  localparam logic [DATA_W-1:0] GFX_MASK = 32'hFFF0_0000;
  localparam logic [DATA_W-1:0] LIM_MASK = 32'h0000_FFFF;
endpackage

// File: rtl/dw_lock_reg.sv
module dw_lock_reg #(
  parameter int W = 32,
  parameter logic [W-1:0] WMASK = '1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic           lock,
  input  logic [W/8-1:0] be,
  input  logic [W-1:0]   wdata,
  output logic [W-1:0]   q
);
  localparam int NB = W / 8;
  logic [W-1:0] q_r;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rst_n)
        q_r[b*8 +: 8] <= '0;
      else if (wr && !lock && be[b])
        q_r[b*8 +: 8] <= (wdata[b*8 +: 8] & WMASK[b*8 +: 8]) |
                         (q_r[b*8 +: 8] & ~WMASK[b*8 +: 8]);
    end
  end

  assign q = q_r & WMASK;
endmodule

// File: rtl/dw_lock_ctl.sv
module dw_lock_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic trust_lock,
  input  logic mgmt_lock,
  input  logic lock_cmd,
  output logic lim_locked,
  output logic gfx_locked,
  output logic cmd_locked
);
  always_ff @(posedge clk) begin
    if (!rst_n)        cmd_locked <= 1'b0;
    else if (lock_cmd) cmd_locked <= 1'b1;
  end

  assign lim_locked = trust_lock;
  assign gfx_locked = mgmt_lock | lock_cmd | cmd_locked;
endmodule

// File: rtl/dw_upper_decode.sv
module dw_upper_decode #(
  parameter int ADDR_W  = 36,
  parameter int GRAN_SH = 20,
  parameter int LOW_SH  = 32
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic [ADDR_W-GRAN_SH-1:0] limit,
  output logic                      hit
);
  localparam int RW = ADDR_W - GRAN_SH;
  logic [RW-1:0] region;
  logic          above_low;
  logic          below_top;

  assign region    = addr[ADDR_W-1:GRAN_SH];
  assign above_low = |addr[ADDR_W-1:LOW_SH];
  assign below_top = region < limit;
  assign hit       = above_low & below_top;
endmodule

// File: rtl/dram_window_regs.sv
module dram_window_regs
  import dram_win_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [3:0]        cfg_off,
  input  logic [BE_W-1:0]   cfg_be,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              trust_lock,
  input  logic              mgmt_lock,
  input  logic              lock_cmd,
  input  logic [ADDR_W-1:0] host_addr,
  output logic              dram_hit
);
  logic [1:0]        word;
  logic              lim_locked, gfx_locked, cmd_locked;
  logic [DATA_W-1:0] lim_word, gfx_q;
  logic [LIM_W-1:0]  lim_q;

  assign word = cfg_off[3:2];

  dw_lock_ctl u_lock (
    .clk(clk), .rst_n(rst_n), .trust_lock(trust_lock), .mgmt_lock(mgmt_lock),
    .lock_cmd(lock_cmd), .lim_locked(lim_locked), .gfx_locked(gfx_locked),
    .cmd_locked(cmd_locked)
  );

  dw_lock_reg #(.W(DATA_W), .WMASK(LIM_MASK)) u_lim (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr && word == WORD_LIMIT),
    .lock(lim_locked), .be(cfg_be), .wdata(cfg_wdata), .q(lim_word)
  );

  dw_lock_reg #(.W(DATA_W), .WMASK(GFX_MASK)) u_gfx (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr && word == WORD_GFX),
    .lock(gfx_locked), .be(cfg_be), .wdata(cfg_wdata), .q(gfx_q)
  );

  assign lim_q = lim_word[LIM_W-1:0];

  always_comb begin
    case (word)
      WORD_LIMIT: cfg_rdata = lim_word;
      WORD_GFX:   cfg_rdata = gfx_q;
      default:    cfg_rdata = '0;
    endcase
  end

  dw_upper_decode #(.ADDR_W(ADDR_W), .GRAN_SH(GRAN_SH), .LOW_SH(LOW_GB_SH)) u_dec (
    .addr(host_addr), .limit(lim_q), .hit(dram_hit)
  );
endmodule

// File: rtl/dram_window_regs_chk.sv
module dram_window_regs_chk
  import dram_win_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              trust_lock,
  input logic              mgmt_lock,
  input logic              lock_cmd,
  input logic              cmd_locked,
  input logic [LIM_W-1:0]  lim_q,
  input logic [DATA_W-1:0] gfx_q,
  input logic [ADDR_W-1:0] host_addr,
  input logic              dram_hit
);
  assert_limit_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trust_lock |=> $stable(lim_q));

  assert_gfx_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_lock || lock_cmd || cmd_locked) |=> $stable(gfx_q));

  assert_cmd_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_locked |=> cmd_locked);

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gfx_q[19:0] == 20'h0);

  assert_low_limit_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_q <= FOUR_GB_REGION) |-> !dram_hit);

  assert_hit_above_4g_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dram_hit |-> (host_addr >= (ADDR_W'(1) << LOW_GB_SH)));
endmodule

bind dram_window_regs dram_window_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .trust_lock(trust_lock), .mgmt_lock(mgmt_lock),
  .lock_cmd(lock_cmd), .cmd_locked(cmd_locked), .lim_q(lim_q), .gfx_q(gfx_q),
  .host_addr(host_addr), .dram_hit(dram_hit)
);

// File: tb/dram_window_regs_bench.sv
`timescale 1ns/1ps
module dram_window_regs_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_wr = 0;
  logic [3:0]  cfg_off = 0;
  logic [3:0]  cfg_be = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic        trust_lock = 0, mgmt_lock = 0, lock_cmd = 0;
  logic [35:0] host_addr = 0;
  logic        dram_hit;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  dram_window_regs u_dram_window_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_off(cfg_off), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .trust_lock(trust_lock),
    .mgmt_lock(mgmt_lock), .lock_cmd(lock_cmd), .host_addr(host_addr), .dram_hit(dram_hit)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] off, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_off = off; cfg_be = be; cfg_wdata = d; cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0; cfg_be = 0;
  endtask

  function automatic logic [31:0] rd(input logic [3:0] off);
    cfg_off = off;
    return cfg_rdata;
  endfunction

  task automatic read_chk(input string req, input logic [3:0] off, input logic [31:0] exp);
    cfg_off = off;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic sweep(input string req, input logic [15:0] lim);
    int bad = 0;
    logic got_first = 0;
    logic [31:0] g0 = 0, e0 = 0;
    for (int r = 0; r < 65536; r++) begin
      logic exp_h;
      host_addr = {r[15:0], (r[0] ? 20'hFFFFF : 20'h00000)};
      exp_h = (r >= 32'h1000) && (r < int'(lim));
      #0.1;
      if (dram_hit !== exp_h) begin
        bad++;
        if (!got_first) begin
          got_first = 1; g0 = {31'b0, dram_hit}; e0 = {31'b0, exp_h};
          $display("  mismatch at region %h limit %h", r[15:0], lim);
        end
      end
    end
    n_run++;
    if (bad != 0) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (%0d mismatches)", req, g0, e0, bad);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    read_chk("R1 limit", 4'h0, 32'h0);
    read_chk("R1 gfx", 4'h4, 32'h0);
    host_addr = 36'hF_FFFF_FFFF; #1;
    check("R1 hit", {31'b0, dram_hit}, 32'h0);

    // R2 byte enables on the limit word
    wr(4'h0, 4'b0001, 32'h1234_ABCD);
    read_chk("R2 byte0", 4'h0, 32'h0000_00CD);
    wr(4'h0, 4'b0010, 32'h1234_ABCD);
    read_chk("R2 byte1", 4'h0, 32'h0000_ABCD);
    wr(4'h0, 4'b1100, 32'hFFFF_0000);
    read_chk("R2 upper ignored", 4'h0, 32'h0000_ABCD);

    // R3 graphics base reserved bits
    wr(4'h4, 4'b1111, 32'hFFFF_FFFF);
    read_chk("R3 gfx all ones", 4'h4, 32'hFFF0_0000);
    wr(4'h4, 4'b0100, 32'h0000_0000);
    read_chk("R3 gfx byte2", 4'h4, 32'hFF00_0000);

    // R9 unmapped offsets
    wr(4'h8, 4'b1111, 32'h5555_5555);
    wr(4'hC, 4'b1111, 32'h5555_5555);
    read_chk("R9 off8 reads zero", 4'h8, 32'h0);
    read_chk("R9 limit kept", 4'h0, 32'h0000_ABCD);
    read_chk("R9 gfx kept", 4'h4, 32'hFF00_0000);

    // R4 / R5 sweeps
    wr(4'h0, 4'b0011, 32'h0);       sweep("R5 limit 0", 16'h0);
    wr(4'h0, 4'b0011, 32'h0FFF);    sweep("R5 limit below 4G", 16'h0FFF);
    wr(4'h0, 4'b0011, 32'h1000);    sweep("R5 limit at 4G", 16'h1000);
    wr(4'h0, 4'b0011, 32'h1001);    sweep("R4 limit 4G+1M", 16'h1001);
    wr(4'h0, 4'b0011, 32'h8A53);    sweep("R4 limit mid", 16'h8A53);
    wr(4'h0, 4'b0011, 32'hFFFF);    sweep("R4 limit max", 16'hFFFF);

    // R10 decode follows new limit right after write edge
    host_addr = 36'h2_0000_0000;
    wr(4'h0, 4'b0011, 32'h2000);
    #1; check("R10 at limit no hit", {31'b0, dram_hit}, 32'h0);
    @(negedge clk); cfg_off = 4'h0; cfg_be = 4'b0011; cfg_wdata = 32'h2001; cfg_wr = 1;
    @(posedge clk); #1; cfg_wr = 0;
    check("R10 hit after edge", {31'b0, dram_hit}, 32'h1);

    // R6 trust lock
    trust_lock = 1;
    wr(4'h0, 4'b0011, 32'h3333);
    read_chk("R6 locked", 4'h0, 32'h0000_2001);
    trust_lock = 0;
    wr(4'h0, 4'b0011, 32'h3333);
    read_chk("R6 released", 4'h0, 32'h0000_3333);

    // R7 management lock
    mgmt_lock = 1;
    wr(4'h4, 4'b1100, 32'h1230_0000);
    read_chk("R7 locked", 4'h4, 32'hFF00_0000);
    mgmt_lock = 0;
    wr(4'h4, 4'b1100, 32'h1230_0000);
    read_chk("R7 released", 4'h4, 32'h1230_0000);

    // R8 lock command, same-cycle write ignored, sticky
    @(negedge clk);
    cfg_off = 4'h4; cfg_be = 4'b1100; cfg_wdata = 32'hABC0_0000; cfg_wr = 1; lock_cmd = 1;
    @(negedge clk);
    cfg_wr = 0; lock_cmd = 0;
    read_chk("R8 same cycle", 4'h4, 32'h1230_0000);
    wr(4'h4, 4'b1100, 32'h7770_0000);
    read_chk("R8 sticky", 4'h4, 32'h1230_0000);
    wr(4'h0, 4'b0011, 32'h4444);
    read_chk("R8 limit unaffected", 4'h0, 32'h0000_4444);

    // R1 reset clears the sticky lock and both settings
    @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
    read_chk("R1 limit after reset", 4'h0, 32'h0);
    wr(4'h4, 4'b1000, 32'h5500_0000);
    read_chk("R1 gfx writable after reset", 4'h4, 32'h5500_0000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule